// File: doc/BRIEF.md
# Configurable PAL Macrocell Array

A small programmable-logic fabric described in synthesizable logic. A configuration image, shifted in one bit per clock, decides which literals each product term of a wide AND plane takes in. The literals are the primary inputs in both polarities, plus the inverted outputs of a shared pool of expander terms. Each expander is itself a product term over the primary inputs only. Its complement re-enters the plane, so a macrocell term can contain factors such as NOT(x AND y) and the fabric can build products of products.

Each macrocell ORs a small, fixed set of its own product terms. It can invert that sum, and it presents either the combinational value or the value held in a flip-flop clocked by the global clock. Functions that need more product terms than the fixed OR width can still fit, in two ways. Some can be factored through expanders. Others can be built from their complement, which may need fewer terms, with the output inversion set.

Top module: `pal_array`

## Requirements
- R1: A product term is the AND of the literals its mask selects. Literal column 2i is primary input i in true form, and column 2i+1 is input i complemented. For macrocell terms, column 2*N_IN+e is the complement of expander e.
- R2: A product term whose mask selects no literal evaluates to 1.
- R3: A product term that selects both polarities of the same input evaluates to 0 for every input pattern. This is how an unused term is switched off.
- R4: Each macrocell output is the OR of exactly its own N_PT product terms (default 3). That connection is fixed, and inputs that no term selects have no effect on the output.
- R5: An expander is a product term over the primary-input columns only. Its inverted value is available as an extra AND-plane column, and the two-pass path settles combinationally within one cycle.
- R6: The macrocell inversion bit, when set, complements the sum-of-products result.
- R7: The mode bit selects the output source. With mode 0 the output shows the combinational result in the same cycle. With mode 1 it shows a flip-flop that captures the combinational result at every rising clock edge.
- R8: Configuration is shifted in on cfg_din, one bit per clock, while cfg_load_en is high. The first bit shifted lands at image bit 0 after CFG_W bits. The image replaces the active configuration at the first clock edge that samples cfg_load_en low after it was high, and it is stable otherwise. The image holds the expander masks first: expander e occupies bits e*2*N_IN upward, 2*N_IN bits each. Macrocell m follows at N_EXP*2*N_IN + m*MC_W, where MC_W = N_PT*(2*N_IN+N_EXP)+2. Within a macrocell, term p is at p*(2*N_IN+N_EXP), then the inversion bit, then the mode bit.
- R9: While cfg_load_en is high, every macrocell output reads 0.
- R10: A synchronous active-high reset clears every macrocell flip-flop to 0. It leaves both the shifting image and the active configuration untouched, including when it occurs in the middle of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst | input | 1 | Synchronous active-high reset of the macrocell flip-flops |
| cfg_load_en | input | 1 | High while the configuration image is being shifted |
| cfg_din | input | 1 | Serial configuration bit |
| pin | input | N_IN | Primary input bus |
| mc_out | output | N_MC | Macrocell output bus |

## Verification
Reset and configuration loading can fall in the same cycles. The bench raises reset for a stretch in the middle of a configuration shift. The fabric must then behave exactly as the second image dictates over a full input sweep, which shows that reset neither stalled nor cleared the chain. Reset and the registered output capture also coincide. With an input that drives the registered macrocell's combinational result to 1, reset is asserted across a clock edge. The registered output must read 0 while a combinational macrocell in the same image keeps computing its function. The registered output must return to 1 one edge after reset drops.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Output source of a macrocell.
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

    // Control field that follows the term masks of a macrocell (inv is the lower bit).
    typedef struct packed {
        out_mode_e mode;
        logic      inv;
    } mc_ctl_t;

    // Width of one macrocell term mask: both polarities of each input plus one column per expander.
    function automatic int term_width(int n_in, int n_exp);
        return 2 * n_in + n_exp;
    endfunction

    // Width of one expander mask: primary-input literals only.
    function automatic int exp_width(int n_in);
        return 2 * n_in;
    endfunction

    // Bits occupied by one macrocell in the image.
    function automatic int mc_width(int n_in, int n_pt, int n_exp);
        return n_pt * term_width(n_in, n_exp) + $bits(mc_ctl_t);
    endfunction

    // Total image length.
    function automatic int cfg_width(int n_in, int n_mc, int n_pt, int n_exp);
        return n_exp * exp_width(n_in) + n_mc * mc_width(n_in, n_pt, n_exp);
    endfunction

    // First bit of macrocell m.
    function automatic int mc_base(int n_in, int n_pt, int n_exp, int m);
        return n_exp * exp_width(n_in) + m * mc_width(n_in, n_pt, n_exp);
    endfunction

endpackage

// File: rtl/pal_term.sv
// One AND-plane product line: AND of the selected literals.
module pal_term #(
    parameter int W = 16
) (
    input  logic [W-1:0] lits,
    input  logic [W-1:0] sel,
    output logic         hit
);
    // An unselected column contributes 1, so an empty mask gives 1.
    // Selecting a literal and its complement always yields 0.
    always_comb begin
        hit = &(lits | ~sel);
    end
endmodule

// File: rtl/pal_cfg_chain.sv
// Serial configuration shift chain with an active copy taken when loading ends.
module pal_cfg_chain #(
    parameter int W = 312
) (
    input  logic         clk,
    input  logic         load_en,
    input  logic         din,
    output logic [W-1:0] shift_q,
    output logic [W-1:0] active_q
);
    logic load_d;

    // Shift toward bit 0: the first bit in ends at bit 0 after W shifts.
    always_ff @(posedge clk) begin
        if (load_en) begin
            shift_q <= {din, shift_q[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        load_d <= load_en;
    end

    // Commit the image once loading has finished.
    always_ff @(posedge clk) begin
        if (load_d && !load_en) begin
            active_q <= shift_q;
        end
    end
endmodule

// File: rtl/pal_macrocell.sv
// Macrocell: fixed OR of N_PT terms, programmable inversion, register or bypass.
module pal_macrocell
    import pal_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_PT  = 3,
    parameter int N_EXP = 4,
    localparam int TW   = term_width(N_IN, N_EXP),
    localparam int MW   = mc_width(N_IN, N_PT, N_EXP)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] lits,
    input  logic [MW-1:0] cfg,
    output logic          comb,
    output logic          q,
    output logic          y
);
    logic [N_PT-1:0] hits;
    mc_ctl_t         ctl;

    assign ctl = mc_ctl_t'(cfg[N_PT*TW +: $bits(mc_ctl_t)]);

    for (genvar p = 0; p < N_PT; p++) begin : g_pt
        pal_term #(.W(TW)) term_i (
            .lits (lits),
            .sel  (cfg[p*TW +: TW]),
            .hit  (hits[p])
        );
    end

    always_comb begin
        comb = (|hits) ^ ctl.inv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= comb;
        end
    end

    always_comb begin
        y = (ctl.mode == OUT_REG) ? q : comb;
    end
endmodule

// File: rtl/pal_array.sv
// Top: configuration chain, expander pool, literal fan-out and macrocells.
module pal_array
    import pal_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_MC  = 4,
    parameter int N_PT  = 3,
    parameter int N_EXP = 4,
    localparam int EW    = exp_width(N_IN),
    localparam int TW    = term_width(N_IN, N_EXP),
    localparam int MW    = mc_width(N_IN, N_PT, N_EXP),
    localparam int CFG_W = cfg_width(N_IN, N_MC, N_PT, N_EXP)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_load_en,
    input  logic            cfg_din,
    input  logic [N_IN-1:0] pin,
    output logic [N_MC-1:0] mc_out
);
    logic [CFG_W-1:0] cfg_shift;
    logic [CFG_W-1:0] cfg_active;
    logic [EW-1:0]    in_lits;
    logic [N_EXP-1:0] exp_hit;
    logic [TW-1:0]    plane_lits;
    logic [N_MC-1:0]  mc_comb;
    logic [N_MC-1:0]  mc_q;
    logic [N_MC-1:0]  mc_y;

    pal_cfg_chain #(.W(CFG_W)) chain_i (
        .clk      (clk),
        .load_en  (cfg_load_en),
        .din      (cfg_din),
        .shift_q  (cfg_shift),
        .active_q (cfg_active)
    );

    // Both polarities of every primary input.
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign in_lits[2*i]   = pin[i];
        assign in_lits[2*i+1] = ~pin[i];
    end

    // First pass: expanders see primary-input literals only, so no loop can form.
    for (genvar e = 0; e < N_EXP; e++) begin : g_exp
        pal_term #(.W(EW)) exp_i (
            .lits (in_lits),
            .sel  (cfg_active[e*EW +: EW]),
            .hit  (exp_hit[e])
        );
    end

    // Second pass columns: inverted expanders appended to the input literals.
    assign plane_lits = {~exp_hit, in_lits};

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        pal_macrocell #(
            .N_IN  (N_IN),
            .N_PT  (N_PT),
            .N_EXP (N_EXP)
        ) mc_i (
            .clk  (clk),
            .rst  (rst),
            .lits (plane_lits),
            .cfg  (cfg_active[mc_base(N_IN, N_PT, N_EXP, m) +: MW]),
            .comb (mc_comb[m]),
            .q    (mc_q[m]),
            .y    (mc_y[m])
        );
    end

    // Outputs are quiet while an image is being shifted.
    assign mc_out = cfg_load_en ? '0 : mc_y;
endmodule

// File: rtl/pal_array_chk.sv
// Assertion checker, bound to pal_array.
module pal_array_chk #(
    parameter int N_MC  = 4,
    parameter int CFG_W = 312
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_load_en,
    input logic [N_MC-1:0]  mc_out,
    input logic [CFG_W-1:0] cfg_shift,
    input logic [CFG_W-1:0] cfg_active,
    input logic [N_MC-1:0]  mc_comb,
    input logic [N_MC-1:0]  mc_q
);
    // R9: outputs read zero during loading.
    p_quiet_load_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_load_en |-> mc_out == '0);

    // R10: reset clears the macrocell flip-flops.
    p_flop_clear_r10: assert property (@(posedge clk)
        rst |=> mc_q == '0);

    // R7: out of reset, the flip-flops capture the combinational result.
    p_reg_capture_r7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> mc_q == $past(mc_comb));

    // R8: the shift chain moves only while loading.
    p_shift_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_load_en |=> $stable(cfg_shift));

    // R8: when loading ends, the shifted image becomes active.
    p_cfg_commit_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_load_en) |=> cfg_active == $past(cfg_shift));

    // R8: the active image changes only on the end of a load.
    p_cfg_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !$fell(cfg_load_en) |=> $stable(cfg_active));
endmodule

bind pal_array pal_array_chk #(
    .N_MC  (N_MC),
    .CFG_W (CFG_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_load_en (cfg_load_en),
    .mc_out      (mc_out),
    .cfg_shift   (cfg_shift),
    .cfg_active  (cfg_active),
    .mc_comb     (mc_comb),
    .mc_q        (mc_q)
);

// File: tb/pal_array_tb_top.sv
module pal_array_tb_top;
    localparam int NI = 8;
    localparam int NM = 4;
    localparam int NP = 3;
    localparam int NE = 4;
    localparam int EW = 2 * NI;
    localparam int TW = 2 * NI + NE;
    localparam int MW = NP * TW + 2;
    localparam int CW = NE * EW + NM * MW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_load_en = 1'b0;
    logic          cfg_din = 1'b0;
    logic [NI-1:0] pin = '0;
    logic [NM-1:0] mc_out;

    logic [CW-1:0] img;
    int            n_run = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    pal_array #(.N_IN(NI), .N_MC(NM), .N_PT(NP), .N_EXP(NE)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_load_en (cfg_load_en),
        .cfg_din     (cfg_din),
        .pin         (pin),
        .mc_out      (mc_out)
    );

    task automatic chk(input string req, input logic act, input logic exp, input int vec);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s vec=%0d actual=%b expected=%b", req, vec, act, exp);
        end
    endtask

    // Image builders: col 2i = input i true, 2i+1 = complement, 2*NI+e = NOT expander e.
    function automatic int mcb(int m);
        return NE * EW + m * MW;
    endfunction
    task automatic term_lit(int m, int p, int col);
        img[mcb(m) + p * TW + col] = 1'b1;
    endtask
    task automatic term_off(int m, int p);
        term_lit(m, p, 0);
        term_lit(m, p, 1);
    endtask
    task automatic exp_lit(int e, int col);
        img[e * EW + col] = 1'b1;
    endtask
    task automatic mc_ctl(int m, logic inv, logic regd);
        img[mcb(m) + NP * TW]     = inv;
        img[mcb(m) + NP * TW + 1] = regd;
    endtask

    // Shift the image, bit 0 first; reset is held for bits [r_lo, r_hi).
    task automatic load_img(int r_lo, int r_hi);
        for (int i = 0; i < CW; i++) begin
            @(negedge clk);
            rst = (i >= r_lo && i < r_hi);
            cfg_din = img[i];
            cfg_load_en = 1'b1;
            if (i % 64 == 5) begin
                #1;
                chk("R9", mc_out == '0, 1'b1, i);
            end
        end
        @(negedge clk);
        rst = 1'b0;
        cfg_load_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic a, b, c, d, f, g;
        // ---------------- Image 1 ----------------
        img = '0;
        exp_lit(0, 0); exp_lit(0, 2);               // exp0 = A&B
        exp_lit(1, 1); exp_lit(1, 4);               // exp1 = A'&C
        term_lit(0, 0, 2*NI+0); term_lit(0, 0, 4); term_lit(0, 0, 6); // ~(AB)CD
        term_lit(0, 1, 2*NI+1); term_lit(0, 1, 2);                    // ~(A'C)B
        term_off(0, 2);
        mc_ctl(0, 1'b0, 1'b0);
        term_lit(1, 0, 0); term_lit(1, 0, 2); term_lit(1, 0, 4); term_lit(1, 0, 6);
        term_lit(1, 1, 1); term_lit(1, 1, 7);
        term_lit(1, 2, 1); term_lit(1, 2, 5);
        mc_ctl(1, 1'b1, 1'b0);                      // complement of a four-term function
        term_off(2, 1); term_off(2, 2);             // term 0 left empty
        mc_ctl(2, 1'b0, 1'b0);
        term_lit(3, 0, 8); term_lit(3, 0, 11);      // in4 & ~in5, registered
        term_off(3, 1); term_off(3, 2);
        mc_ctl(3, 1'b0, 1'b1);

        repeat (3) @(negedge clk);
        // Loading starts while reset is still high.
        load_img(0, 4);

        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            pin = v[NI-1:0];
            #1;
            chk("R7 bypass unaffected before edge", mc_out[0],
                (~pin[0] & pin[2] & pin[3]) | (~pin[1] & pin[2] & pin[3]) |
                (pin[0] & pin[1]) | (pin[1] & ~pin[2]), v);
            @(negedge clk);
            a = pin[0]; b = pin[1]; c = pin[2]; d = pin[3];
            f = (~a & c & d) | (~b & c & d) | (a & b) | (b & ~c);
            g = (a & ~b) | (a & ~c) | (a & ~d) | (~a & c & d);
            chk("R1 R5 expander function", mc_out[0], f, v);
            chk("R6 inverted complement", mc_out[1], g, v);
            chk("R2 empty term", mc_out[2], 1'b1, v);
            chk("R7 registered", mc_out[3], pin[4] & ~pin[5], v);
        end

        // Registered output timing: change lands only after the edge.
        @(negedge clk); pin = 8'h00;
        @(negedge clk); pin = 8'h10;
        #1;
        chk("R7 old value before edge", mc_out[3], 1'b0, 300);
        @(negedge clk);
        chk("R7 new value after edge", mc_out[3], 1'b1, 301);

        // Reset clears the flop, config survives.
        rst = 1'b1;
        @(negedge clk);
        chk("R10 flop cleared", mc_out[3], 1'b0, 302);
        chk("R10 config intact", mc_out[0], 1'b0, 302);
        pin = 8'h13;
        #1;
        chk("R10 config intact", mc_out[0], 1'b1, 303);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 flop recaptures", mc_out[3], 1'b1, 304);

        // ---------------- Image 2 (reset in mid-load) ----------------
        pin = 8'hFF;
        img = '0;
        term_lit(0, 0, 0); term_lit(0, 1, 2); term_lit(0, 2, 4);        // in0|in1|in2
        mc_ctl(0, 1'b0, 1'b0);
        term_lit(1, 0, 0); term_lit(1, 0, 1);
        term_lit(1, 1, 2); term_lit(1, 1, 3);
        term_lit(1, 2, 4); term_lit(1, 2, 5);
        mc_ctl(1, 1'b0, 1'b0);
        exp_lit(2, 12); exp_lit(2, 14);                                  // exp2 = in6&in7
        term_lit(2, 0, 2*NI+2); term_off(2, 1); term_off(2, 2);
        mc_ctl(2, 1'b1, 1'b0);                                           // NOT NOT exp2
        term_lit(3, 0, 6); term_off(3, 1); term_off(3, 2);
        mc_ctl(3, 1'b0, 1'b0);                                           // in3, bypass
        load_img(100, 120);

        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            pin = v[NI-1:0];
            #1;
            chk("R4 fixed OR", mc_out[0], pin[0] | pin[1] | pin[2], v);
            chk("R3 both polarities", mc_out[1], 1'b0, v);
            chk("R5 R6 expander inverted", mc_out[2], pin[6] & pin[7], v);
            chk("R7 R8 bypass same cycle", mc_out[3], pin[3], v);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule